// File: doc/BRIEF.md
# DMA Sub-Channel Bus Arbiter

This block decides which of four DMA sub-channels may use a shared system bus. The sub-channels form two groups (0 and 1), and each group has two slots (A and B). The slot index is 0 = 0A, 1 = 0B, 2 = 1A and 3 = 1B. When a sub-channel wants a transfer, the arbiter first asks the system bus master for the bus. When the grant arrives, it picks the most urgent requester and starts one unit transfer, which is one byte or one word. The unit ends with a done pulse from the transfer engine. The arbiter then either keeps the bus for another unit or hands it back.

Which channels may compete depends on the address-mode select. In short-address mode all four slots compete, and the lower slot index wins. In full-address mode only the A slots (indices 0 and 2) may compete, and group 0 wins over group 1.

Whether the bus is kept after a unit depends on the address mode and on each channel's transfer mode:
- Single/cycle-steal transfers hand the bus back after every unit.
- Burst and block transfers in full-address mode keep the bus until the channel drops its request.
- They give it up early when a more urgent channel or an outside, more urgent bus master asks for the bus.

Top module: `dma_arb`

## Requirements
- R1: After reset, `busReq`, `actValid`, `startStb` and `relStb` are all 0.
- R2: Ineligible requests are ignored. In short-address mode (`addrFull`=0) all four slots are eligible. In full-address mode (`addrFull`=1) only slots 0 and 2 are eligible, and requests on slots 1 and 3 never raise `busReq`.
- R3: While idle, an eligible request raises `busReq` one clock later. `busReq` stays high without a channel starting until `busGrant` is seen. The grant then latches the eligible requester with the lowest slot index into `actCh` and raises `actValid` and `startStb` one clock later.
- R4: In full-address mode, channel 0 (slot 0) wins over channel 1 (slot 2). Slots 1 and 3 neither win nor preempt.
- R5: While `actValid` is high, `actCh` holds its value. Requests that appear later do not change it.
- R6: In short-address mode the bus is handed back after every unit, whatever the transfer mode.
- R7: In full-address mode, a channel in single/cycle-steal mode (`chMode` field 2'b00) hands the bus back after every unit.
- R8: In full-address mode, a channel in burst (2'b01) or block (2'b10 or 2'b11) mode keeps the bus after a unit and pulses `startStb` one clock after `unitDone`. This continues while its own request is still high at the `unitDone` cycle. The bus is handed back at the first `unitDone` where that request is low.
- R9: A burst or block channel hands the bus back at the next `unitDone` if a more urgent eligible channel is requesting. The preempted channel resumes later through normal arbitration.
- R10: A burst or block channel hands the bus back at the next `unitDone` if `hiMasterReq` is high. It is never taken away in the middle of a unit.
- R11: A hand-back pulses `relStb` with `busReq` low in that same cycle. If an eligible request is still pending, `busReq` rises again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chReq | input | 4 | Per-slot transfer request, bit i = slot i |
| chMode | input | 8 | Per-slot transfer mode, bits [2i+1:2i] for slot i |
| addrFull | input | 1 | 1 = full-address mode, 0 = short-address mode |
| busGrant | input | 1 | Bus granted by the system bus master |
| hiMasterReq | input | 1 | A more urgent outside bus master wants the bus |
| unitDone | input | 1 | Current byte/word unit finished (one-cycle pulse) |
| busReq | output | 1 | Request for the system bus |
| actValid | output | 1 | A channel owns the bus |
| actCh | output | 2 | Slot index of the owning channel |
| startStb | output | 1 | One-cycle pulse when a unit starts |
| relStb | output | 1 | One-cycle pulse when the bus is handed back |

## Verification
The assertions assume three things about the inputs:
- `unitDone` pulses only while a channel owns the bus.
- `addrFull` and the active channel's mode are not changed while a channel owns the bus.
- `busGrant` is only asserted in answer to `busReq`.

The stimulus respects these assumptions:
- `busGrant` is raised only after `busReq` has been seen high.
- `unitDone` is raised only after `actValid` is seen.
- Mode inputs are changed only while the arbiter is idle.

Request and `hiMasterReq` changes are free to land in any cycle, including in the middle of a unit.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  // Per-channel transfer mode. The two block codes behave the same here.
  typedef enum logic [1:0] {
    MODE_SINGLE    = 2'b00,
    MODE_BURST     = 2'b01,
    MODE_BLOCK     = 2'b10,
    MODE_BLOCK_ALT = 2'b11
  } xfer_mode_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic latchSel;   // capture the current winner as the owner
  } arb_ctl_s;

endpackage

// File: rtl/dma_arb_path.sv
module dma_arb_path
  import dma_arb_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CW = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  arb_ctl_s         ctl,
  input  logic [NCH-1:0]   chReq,
  input  logic [2*NCH-1:0] chMode,
  input  logic             addrFull,
  input  logic             hiMasterReq,
  output logic             anyElig,
  output logic             keepBus,
  output logic [CW-1:0]    actCh
);

  logic [NCH-1:0] eligMask;
  logic [NCH-1:0] eligReq;
  logic [CW-1:0]  winner;
  logic           higherPend;
  xfer_mode_e     actMode;

  // Odd slots (B side) only exist in short-address mode.
  for (genvar g = 0; g < NCH; g++) begin : g_elig
    if (g % 2 == 0) begin : g_aSlot
      assign eligMask[g] = 1'b1;
    end else begin : g_bSlot
      assign eligMask[g] = !addrFull;
    end
  end

  assign eligReq = chReq & eligMask;
  assign anyElig = |eligReq;

  // Fixed priority: the lowest index wins.
  always_comb begin
    winner = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (eligReq[i]) winner = CW'(i);
    end
  end

  // Is a more urgent eligible channel waiting?
  always_comb begin
    higherPend = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (eligReq[i] && (CW'(i) < actCh)) higherPend = 1'b1;
    end
  end

  assign actMode = xfer_mode_e'(chMode[{actCh, 1'b0} +: 2]);

  assign keepBus = addrFull && (actMode != MODE_SINGLE) && chReq[actCh]
                   && !higherPend && !hiMasterReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actCh <= '0;
    end else if (ctl.latchSel) begin
      actCh <= winner;
    end
  end

  // R5
  owner_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.latchSel |=> $stable(actCh));

  // R4
  full_a_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.latchSel && addrFull) |=> (actCh[0] == 1'b0));

endmodule

// File: rtl/dma_arb_ctrl.sv
module dma_arb_ctrl
  import dma_arb_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     anyElig,
  input  logic     keepBus,
  input  logic     addrFull,
  input  logic     busGrant,
  input  logic     unitDone,
  output arb_ctl_s ctl,
  output logic     busReq,
  output logic     actValid,
  output logic     startStb,
  output logic     relStb
);

  typedef enum logic [1:0] {ST_IDLE, ST_ASK, ST_RUN} arb_state_e;

  arb_state_e state;
  logic       grabNow;
  logic       unitEnd;

  assign grabNow      = (state == ST_ASK) && busGrant && anyElig;
  assign unitEnd      = (state == ST_RUN) && unitDone;
  assign ctl.latchSel = grabNow;
  assign busReq       = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      actValid <= 1'b0;
      startStb <= 1'b0;
      relStb   <= 1'b0;
    end else begin
      startStb <= 1'b0;
      relStb   <= 1'b0;
      case (state)
        ST_IDLE: if (anyElig) state <= ST_ASK;
        ST_ASK: begin
          if (grabNow) begin
            state    <= ST_RUN;
            actValid <= 1'b1;
            startStb <= 1'b1;
          end else if (busGrant) begin
            state <= ST_IDLE;
          end
        end
        ST_RUN: begin
          if (unitEnd) begin
            if (keepBus) begin
              startStb <= 1'b1;
            end else begin
              state    <= ST_IDLE;
              actValid <= 1'b0;
              relStb   <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R11
  release_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    relStb |-> !busReq);

  // R6
  short_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (unitEnd && !addrFull) |=> (relStb && !actValid));

  // R8
  burst_continue_chk: assert property (@(posedge clk) disable iff (!rstN)
    (unitEnd && keepBus) |=> (startStb && busReq && actValid));

  // R3
  start_needs_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    startStb |-> (busReq && actValid));

endmodule

// File: rtl/dma_arb.sv
module dma_arb
  import dma_arb_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CW = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NCH-1:0]   chReq,
  input  logic [2*NCH-1:0] chMode,
  input  logic             addrFull,
  input  logic             busGrant,
  input  logic             hiMasterReq,
  input  logic             unitDone,
  output logic             busReq,
  output logic             actValid,
  output logic [CW-1:0]    actCh,
  output logic             startStb,
  output logic             relStb
);

  arb_ctl_s ctl;
  logic     anyElig;
  logic     keepBus;

  dma_arb_path #(.NCH(NCH)) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .chReq       (chReq),
    .chMode      (chMode),
    .addrFull    (addrFull),
    .hiMasterReq (hiMasterReq),
    .anyElig     (anyElig),
    .keepBus     (keepBus),
    .actCh       (actCh)
  );

  dma_arb_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .anyElig  (anyElig),
    .keepBus  (keepBus),
    .addrFull (addrFull),
    .busGrant (busGrant),
    .unitDone (unitDone),
    .ctl      (ctl),
    .busReq   (busReq),
    .actValid (actValid),
    .startStb (startStb),
    .relStb   (relStb)
  );

  // R10
  no_midunit_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (actValid && !unitDone) |=> actValid);

endmodule

// File: tb/test_dma_arb.sv
module test_dma_arb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] chReq = '0;
  logic [7:0] chMode = '0;
  logic       addrFull = 1'b0;
  logic       busGrant = 1'b0;
  logic       hiMasterReq = 1'b0;
  logic       unitDone = 1'b0;
  logic       busReq, actValid, startStb, relStb;
  logic [1:0] actCh;

  int nChecks = 0;
  int nFail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dma_arb i_dma_arb (
    .clk(clk), .rstN(rstN), .chReq(chReq), .chMode(chMode),
    .addrFull(addrFull), .busGrant(busGrant), .hiMasterReq(hiMasterReq),
    .unitDone(unitDone), .busReq(busReq), .actValid(actValid),
    .actCh(actCh), .startStb(startStb), .relStb(relStb)
  );

  task automatic checkEq(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected winner: lowest eligible index, -1 if none.
  function automatic int expWinner(input logic [3:0] req, input logic full);
    for (int i = 0; i < 4; i++) begin
      if (req[i] && (!full || (i % 2 == 0))) return i;
    end
    return -1;
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  // Grant the bus (busReq must already be high) and check the owner.
  task automatic grantTo(input int expCh, input string tag);
    busGrant = 1'b1;
    step();
    busGrant = 1'b0;
    checkEq({tag, " actCh"}, int'(actCh), expCh);
    checkEq({tag, " actValid"}, int'(actValid), 1);
    checkEq({tag, " startStb"}, int'(startStb), 1);
  endtask

  // End a unit, applying a new request vector at the same time.
  task automatic endUnit(input logic [3:0] newReq, input bit expKeep, input string tag);
    unitDone = 1'b1;
    chReq = newReq;
    step();
    unitDone = 1'b0;
    if (expKeep) begin
      checkEq({tag, " kept startStb"}, int'(startStb), 1);
      checkEq({tag, " kept busReq"}, int'(busReq), 1);
    end else begin
      checkEq({tag, " relStb"}, int'(relStb), 1);
      checkEq({tag, " busReq low at release"}, int'(busReq), 0);
      checkEq({tag, " actValid cleared"}, int'(actValid), 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    step();
    // R1: reset state
    checkEq("R1 busReq", int'(busReq), 0);
    checkEq("R1 actValid", int'(actValid), 0);
    checkEq("R1 startStb", int'(startStb), 0);
    checkEq("R1 relStb", int'(relStb), 0);
    rstN = 1'b1;
    step();

    // Sweep every request pattern in both address modes: R2, R3, R4
    for (int full = 0; full < 2; full++) begin
      for (int req = 1; req < 16; req++) begin
        automatic int w = expWinner(4'(req), 1'(full));
        addrFull = 1'(full);
        chMode = '0;
        chReq = 4'(req);
        step();
        if (w < 0) begin
          step();
          checkEq($sformatf("R2 ignored req=%0d", req), int'(busReq), 0);
          chReq = '0;
          step();
        end else begin
          checkEq($sformatf("R3 busReq req=%0d", req), int'(busReq), 1);
          step();
          checkEq($sformatf("R3 wait grant busReq req=%0d", req), int'(busReq), 1);
          checkEq($sformatf("R3 wait grant idle req=%0d", req), int'(actValid), 0);
          grantTo(w, $sformatf("R3 R4 full=%0d req=%0d", full, req));
          endUnit(4'b0000, 1'b0, "R7 single");
          step();
        end
      end
    end

    // Modes x address modes x eligible channels: R6, R7, R8, R11
    for (int full = 0; full < 2; full++) begin
      for (int mode = 0; mode < 3; mode++) begin
        for (int ch = 0; ch < 4; ch++) begin
          if (full == 1 && (ch % 2) == 1) continue;
          addrFull = 1'(full);
          chMode = {4{2'(mode)}};
          chReq = 4'(1 << ch);
          step();
          grantTo(ch, "R8 first grant");
          for (int u = 0; u < 3; u++) begin
            automatic bit drop = (u == 2);
            automatic bit keep = (full == 1) && (mode != 0) && !drop;
            endUnit(drop ? 4'b0000 : 4'(1 << ch), keep,
                    $sformatf("R6 R7 R8 full=%0d mode=%0d ch=%0d u=%0d", full, mode, ch, u));
            if (!keep && !drop) begin
              step();
              checkEq("R11 re-request", int'(busReq), 1);
              grantTo(ch, "R11 regrant");
            end
          end
          step();
        end
      end
    end

    // Preemption in full-address mode: R4, R5, R9, R10
    addrFull = 1'b1;
    chMode = 8'b00_01_00_00;        // slot 2 burst, slot 0 single
    chReq = 4'b0100;
    step();
    grantTo(2, "R9 burst owner");
    endUnit(4'b0110, 1'b1, "R4 B slot no preempt");
    chReq = 4'b0111;
    step();
    checkEq("R5 owner held mid-unit", int'(actCh), 2);
    endUnit(4'b0111, 1'b0, "R9 preempt at boundary");
    step();
    checkEq("R9 re-request", int'(busReq), 1);
    grantTo(0, "R9 urgent channel");
    endUnit(4'b0110, 1'b0, "R7 urgent single");
    step();
    grantTo(2, "R9 resume");
    hiMasterReq = 1'b1;
    step();
    checkEq("R10 no mid-unit release", int'(actValid), 1);
    endUnit(4'b0100, 1'b0, "R10 outside master");
    hiMasterReq = 1'b0;
    step();
    grantTo(2, "R10 resume");
    endUnit(4'b0000, 1'b0, "R8 burst finished");
    step();
    checkEq("R11 no pending", int'(busReq), 0);

    // Short mode: late request does not steal the owner (R5)
    addrFull = 1'b0;
    chMode = '0;
    chReq = 4'b1000;
    step();
    grantTo(3, "R5 short owner");
    chReq = 4'b1111;
    step();
    checkEq("R5 short owner held", int'(actCh), 3);
    endUnit(4'b0111, 1'b0, "R6 short release");
    step();
    grantTo(0, "R3 short regrant");
    endUnit(4'b0000, 1'b0, "R6 short final");
    step();

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule